// File: doc/BRIEF.md
# Multi-Mode Accumulator Processor

This block is a small multi-cycle processor built around a single 16-bit accumulator. Program and data share one internal memory of 128 words. Each instruction carries an operation, a two-bit mode that says how the operand value is found, a 7-bit operand field and a 4-bit offset. Five operations exist: load, add, subtract, output and halt.

The memory is filled through a write port that works only while reset is held. After reset the core waits. A one-cycle start pulse begins execution at address 0. The core fetches each word, decodes it and reads only as much memory as the mode needs. Immediate mode reads no operand word. Direct and indexed modes read one. Indirect mode reads a pointer and then the data it points to. Each output instruction makes a one-cycle strobe on the data port. A halt instruction parks the core, and it stays parked until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: Reset clears the accumulator and the program counter and drives `out_valid` and `halted` low. The core then waits for `start`. `load_we` writes memory only while `rst` is high, and reset does not change the memory contents.
- R2: Word layout: bits [15:13] hold the opcode (0 load, 1 add, 2 subtract, 3 output, 4 halt), bits [12:11] the mode (0 immediate, 1 direct, 2 indirect, 3 indexed), bits [10:4] the operand and bits [3:0] the offset. A `start` pulse begins execution at address 0, and instructions run in address order.
- R3: In immediate mode the operand field, zero-extended to 16 bits, is the value used, and no memory read is made for it.
- R4: In direct mode the value is the memory word at the address given by the operand field.
- R5: In indirect mode the word at the operand address is a pointer. Its low 7 bits address the value, so two reads are made one after the other.
- R6: In indexed mode the value is read from address (operand + offset) mod 128.
- R7: Load replaces the accumulator with the value. Add and subtract change the accumulator by the value modulo 2^16.
- R8: Each output instruction raises `out_valid` for exactly one cycle, with `out_data` equal to the accumulator at that moment.
- R9: Opcode 4, and the unused opcodes 5 to 7, stop execution. After that `halted` stays high until reset. `start` is ignored while a program is running or halted.
- R10: Cycle cost per instruction: 3 cycles for immediate, output and halt; 4 for direct and indexed; 5 for indirect. For example, immediate load then output gives `out_valid` 6 cycles after the clock edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; also enables memory loading |
| start | input | 1 | Begin execution at address 0 when the core is idle |
| load_we | input | 1 | Memory write enable, effective only during reset |
| load_addr | input | 7 | Memory write address |
| load_data | input | 16 | Memory write data |
| out_data | output | 16 | Accumulator value captured by an output instruction |
| out_valid | output | 1 | One-cycle strobe for each output instruction |
| halted | output | 1 | High once a halt or reserved opcode has executed |

## Verification
The hardest cases to reach are the ones where an address wraps. One is an indexed sum past address 127. Another is an indirect pointer whose upper bits are set. A third is a pointer that lands inside the program's own code. Directed programs place a base of 126 with an offset of 5, and a pointer word of 0x0085. Seeded random programs let operand and pointer fields fall anywhere in memory, code words included. An instruction-level model in the bench predicts every output. Mode-specific cycle counts are checked by measuring output latency for each mode.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int DW = 16,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          halted
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] OP_LDA = 3'd0, OP_ADD = 3'd1, OP_SUB = 3'd2, OP_OUT = 3'd3;
  localparam logic [1:0] M_IMM = 2'd0, M_IND = 2'd2, M_IDX = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_PTR_READ, S_DATA_READ, S_EXECUTE, S_HALT
  } state_t;

  state_t        state;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q, acc, opnd;
  logic [AW-1:0] pc, rd_addr;
  logic [2:0]    ir_op;

  wire [2:0]    d_op   = mem_q[15:13];
  wire [1:0]    d_mode = mem_q[12:11];
  wire [AW-1:0] d_opd  = mem_q[4 +: AW];
  wire [AW-1:0] d_ea   = d_opd + {{(AW-4){1'b0}}, mem_q[3:0]};

  always_comb begin
    case (state)
      S_DECODE:   rd_addr = (d_mode == M_IDX) ? d_ea : d_opd;
      S_PTR_READ: rd_addr = mem_q[AW-1:0];
      default:    rd_addr = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst && load_we) mem[load_addr] <= load_data;
    mem_q <= mem[rd_addr];
  end

  assign halted = (state == S_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      pc        <= '0;
      acc       <= '0;
      opnd      <= '0;
      ir_op     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state <= S_FETCH;
          pc    <= '0;
        end
        S_FETCH: state <= S_DECODE;
        S_DECODE: begin
          ir_op <= d_op;
          if (d_op > OP_SUB) state <= S_EXECUTE;
          else if (d_mode == M_IMM) begin
            opnd  <= {{(DW-AW){1'b0}}, d_opd};
            state <= S_EXECUTE;
          end else if (d_mode == M_IND) state <= S_PTR_READ;
          else state <= S_DATA_READ;
        end
        S_PTR_READ: state <= S_DATA_READ;
        S_DATA_READ: begin
          opnd  <= mem_q;
          state <= S_EXECUTE;
        end
        S_EXECUTE: begin
          state <= S_FETCH;
          pc    <= pc + 1'b1;
          case (ir_op)
            OP_LDA: acc <= opnd;
            OP_ADD: acc <= acc + opnd;
            OP_SUB: acc <= acc - opnd;
            OP_OUT: begin
              out_valid <= 1'b1;
              out_data  <= acc;
            end
            default: begin
              state <= S_HALT;
              pc    <= pc;
            end
          endcase
        end
        default: state <= S_HALT;
      endcase
    end
  end

  p_imm_no_read_r3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DECODE && d_op <= OP_SUB && d_mode == M_IMM) |=> state == S_EXECUTE);

  p_ptr_then_data_r5: assert property (@(posedge clk) disable iff (rst)
    state == S_PTR_READ |=> state == S_DATA_READ);

  p_ptr_after_decode_r5: assert property (@(posedge clk) disable iff (rst)
    state == S_PTR_READ |-> $past(state) == S_DECODE);

  p_out_single_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_out_source_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(state) == S_EXECUTE && $past(ir_op) == OP_OUT));

  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  p_idle_waits_r1: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !start) |=> state == S_IDLE);
endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, start = 0, load_we = 0;
  logic [6:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic [15:0] out_data;
  logic        out_valid, halted;

  acc_cpu u_dut (.clk, .rst, .start, .load_we, .load_addr, .load_data,
                 .out_data, .out_valid, .halted);

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0, checks = 0;
  logic [15:0] img [128];
  logic [15:0] exp_out [32];
  int exp_n;
  logic [15:0] outs [32];
  int out_cnt = 0, first_lat = -1, t0 = 0;
  bit dbl = 0, prev_v = 0, clr = 0;

  always @(negedge clk) begin
    if (clr) begin
      out_cnt = 0; first_lat = -1; dbl = 0;
    end else if (out_valid) begin
      if (out_cnt < 32) outs[out_cnt] = out_data;
      if (out_cnt == 0) first_lat = cyc - t0;
      out_cnt++;
      if (prev_v) dbl = 1;
    end
    prev_v = out_valid;
  end

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs + 1, checks + 1);
    $finish;
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(int op, int md, int opd, int off);
    enc = {op[2:0], md[1:0], opd[6:0], off[3:0]};
  endfunction

  task automatic model();
    logic [15:0] acc = 0, v, w;
    int pc = 0;
    exp_n = 0;
    for (int s = 0; s < 1000; s++) begin
      w = img[pc];
      if (w[15:13] >= 4) break;
      if (w[15:13] == 3) begin
        if (exp_n < 32) exp_out[exp_n] = acc;
        exp_n++;
      end else begin
        case (w[12:11])
          2'd0: v = {9'd0, w[10:4]};
          2'd1: v = img[w[10:4]];
          2'd2: v = img[img[w[10:4]][6:0]];
          default: v = img[7'(w[10:4] + {3'd0, w[3:0]})];
        endcase
        case (w[15:13])
          3'd0: acc = v;
          3'd1: acc = acc + v;
          default: acc = acc - v;
        endcase
      end
      pc = (pc + 1) % 128;
    end
  endtask

  task automatic do_reset(bit wr);
    @(negedge clk); rst = 1;
    if (wr) for (int a = 0; a < 128; a++) begin
      load_we = 1; load_addr = 7'(a); load_data = img[a];
      @(negedge clk);
    end
    load_we = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic clear_img();
    for (int a = 0; a < 128; a++) img[a] = enc(4, 0, 0, 0);
  endtask

  task automatic plan_data();
    img[4] = 6; img[5] = 2; img[6] = 10; img[7] = 15; img[8] = 16; img[9] = 17;
  endtask

  task automatic go(bit wr, bit restart);
    @(posedge clk); clr = 1; @(posedge clk); clr = 0;
    do_reset(wr);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0; t0 = cyc;
    if (restart) begin
      repeat (5) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run_prog(string req, int exp_lat, bit restart);
    model();
    go(1, restart);
    chk(halted == 1, req, "halted at end", halted, 1);
    chk(out_cnt == exp_n, req, "output count", out_cnt, exp_n);
    for (int i = 0; i < exp_n && i < out_cnt && i < 32; i++)
      chk(outs[i] == exp_out[i], req, $sformatf("output %0d", i), outs[i], exp_out[i]);
    chk(!dbl, "R8", "strobe width", dbl, 0);
    if (exp_lat >= 0) chk(first_lat == exp_lat, "R10", "first output latency", first_lat, exp_lat);
  endtask

  initial begin
    clear_img();
    do_reset(1);
    @(negedge clk);
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(halted == 0, "R1", "halted after reset", halted, 0);
    repeat (20) @(negedge clk);
    chk(halted == 0 && out_cnt == 0, "R1", "idle without start", halted + out_cnt, 0);

    // R4 R3: direct load 16 then immediate add 4
    clear_img(); plan_data();
    img[0] = enc(0, 1, 8, 0); img[1] = enc(1, 0, 4, 0); img[2] = enc(3, 0, 0, 0); img[3] = enc(4, 0, 0, 0);
    run_prog("R4", -1, 0);
    chk(outs[0] == 20, "R3", "direct plus immediate", outs[0], 20);

    // R1: load port ignored out of reset, memory kept over reset
    @(negedge clk); load_we = 1; load_addr = 8; load_data = 99;
    @(negedge clk); load_we = 0;
    go(0, 0);
    chk(out_cnt == 1 && outs[0] == 20, "R1", "write outside reset ignored", outs[0], 20);

    // R4: direct + direct
    img[1] = enc(1, 1, 5, 0);
    run_prog("R4", -1, 0);
    chk(outs[0] == 18, "R4", "direct plus direct", outs[0], 18);

    // R5: indirect via pointer at 5
    img[1] = enc(1, 2, 5, 0); img[5] = 8;
    run_prog("R5", -1, 0);
    chk(outs[0] == 32, "R5", "indirect add", outs[0], 32);

    // R6: indexed 7[2] -> address 9
    clear_img(); plan_data();
    img[0] = enc(0, 0, 5, 0); img[1] = enc(1, 3, 7, 2); img[2] = enc(3, 0, 0, 0);
    run_prog("R6", -1, 0);
    chk(outs[0] == 22, "R6", "indexed add", outs[0], 22);

    // R6: indexed wrap 126+5 -> 3
    clear_img();
    img[0] = enc(0, 3, 126, 5); img[1] = enc(3, 0, 0, 0); img[2] = enc(4, 0, 0, 0); img[3] = 16'h1234;
    run_prog("R6", -1, 0);
    chk(outs[0] == 16'h1234, "R6", "indexed wrap", outs[0], 16'h1234);

    // R5: pointer upper bits ignored, 0x0085 -> 5
    clear_img();
    img[0] = enc(0, 2, 10, 0); img[1] = enc(3, 0, 0, 0); img[10] = 16'h0085; img[5] = 16'hBEEF;
    run_prog("R5", -1, 0);
    chk(outs[0] == 16'hBEEF, "R5", "pointer wrap", outs[0], 16'hBEEF);

    // R7: subtract and add wraparound, two outputs
    clear_img();
    img[0] = enc(0, 0, 3, 0); img[1] = enc(2, 0, 5, 0); img[2] = enc(3, 0, 0, 0);
    img[3] = enc(0, 1, 20, 0); img[4] = enc(1, 0, 1, 0); img[5] = enc(3, 0, 0, 0);
    img[20] = 16'hFFFF;
    run_prog("R7", -1, 0);
    chk(outs[0] == 16'hFFFE, "R7", "subtract wrap", outs[0], 16'hFFFE);
    chk(outs[1] == 0, "R7", "add wrap", outs[1], 0);
    chk(out_cnt == 2, "R8", "one strobe per output", out_cnt, 2);

    // R10: latency per mode
    for (int m = 0; m < 4; m++) begin
      clear_img();
      img[0] = enc(0, m, 10, 1); img[1] = enc(3, 0, 0, 0); img[10] = 12; img[11] = 12; img[12] = 7;
      run_prog("R10", (m == 0) ? 6 : (m == 2) ? 8 : 7, 0);
    end

    // R9: reserved opcode halts, halt sticky, start ignored
    clear_img();
    img[0] = enc(0, 0, 1, 0); img[1] = enc(3, 0, 0, 0); img[2] = enc(6, 0, 0, 0); img[3] = enc(3, 0, 0, 0);
    run_prog("R9", -1, 0);
    chk(out_cnt == 1, "R9", "reserved opcode stops", out_cnt, 1);
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    repeat (20) @(negedge clk);
    chk(halted == 1, "R9", "halted sticky", halted, 1);
    chk(out_cnt == 1, "R9", "no run after halt", out_cnt, 1);

    // R2 R9: random programs, one with a start pulse mid-run
    void'($urandom(1234));
    for (int t = 0; t < 40; t++) begin
      int n = 2 + ($urandom % 5), p = 0;
      for (int a = 0; a < 128; a++) img[a] = 16'($urandom);
      for (int k = 0; k < n; k++) begin
        img[p++] = enc($urandom % 3, $urandom % 4, $urandom % 128, $urandom % 16);
        img[p++] = enc(3, 0, 0, 0);
      end
      img[p] = enc(4 + ($urandom % 4), 0, 0, 0);
      run_prog((t == 0) ? "R9" : "R2", -1, t == 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule